// File: doc/BRIEF.md
# Non-Destructive Memory Size Probe

This block is a small bus master that answers two questions about a memory window: whether working RAM is present there, and how many bytes it spans. A pulse on `start` latches a base address and an upper size bound, which must be a power of two of at least 4. The probe then runs a fixed series of single-word reads and writes on a synchronous valid/ready memory port. When it finishes, it raises `done` for one cycle and publishes a size in bytes, with a present flag. A size of zero means that nothing answered, or that what answered is defective.

The probe saves the two words at the base before it writes anything, and it puts them back before it reports. It never writes any other location, so data held higher in the window survives the probe. To check for presence, it writes a pattern to the base and then writes a second, complementary pattern to base+4 before it reads the base back. A floating data bus that only remembers the last value driven therefore cannot pass for RAM. To measure the size, it steps a power-of-two offset upward from 4. At each step it writes the inverse of the word at that offset to the base, then reads both locations again. When they agree, the address has wrapped onto the base, and the offset is the size.

Top module: `ram_size_probe`

## Requirements
- R1: The words at base+0 and base+4 are read before any write, and the same values are written back to those two addresses before `done`, on every outcome.
- R2: First presence pass: the probe writes 0x5555AAAA to base+0, then 0xAAAA5555 to base+4, then reads base+0. Any value other than 0x5555AAAA ends the probe with size 0 after 7 requests in total (2 save reads, 3 test accesses, 2 restore writes).
- R3: Second presence pass: the probe writes 0xAAAA5555 to base+0, then 0x5555AAAA to base+4, then reads base+0. Any value other than 0xAAAA5555 ends the probe with size 0 after 10 requests in total.
- R4: A write to base+4 always sits between a write to base+0 and its readback. A bus that returns the last value driven on it is therefore reported as size 0.
- R5: For offsets 4, 8, 16 and so on below the bound, the probe reads the word at the offset, writes its bitwise inverse to base+0, then reads base+0 and the offset word. The first offset where the two reads match is reported as the size.
- R6: If every offset below the bound fails to wrap, the reported size equals the bound. This includes a bound of 4, where no offset is tested.
- R7: Writes go only to base+0 and base+4.
- R8: `done` is high for exactly one cycle per probe. When `done` is high, `present` is 1 exactly when the size is non-zero.
- R9: `size_bytes` and `present` hold their values from one `done` until the next probe's `done`. A `start` while `busy` is high has no effect.
- R10: A request holds `req_valid`, `req_addr`, `req_we` and `req_wdata` steady until `req_ready` accepts it. A read completes only on `rsp_valid`, and only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only while idle |
| base_addr | input | ADDR_W | Byte address of the window base |
| max_size | input | ADDR_W | Size bound in bytes, a power of two of at least 4 |
| busy | output | 1 | High while a probe is running |
| done | output | 1 | One-cycle completion pulse |
| present | output | 1 | Memory detected on the last probe |
| size_bytes | output | ADDR_W | Detected size in bytes, 0 if absent or defective |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Request byte address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_rdata | input | 32 | Read data |

## Verification
The assertions watch the properties that hold on every cycle. Writes must stay inside the first two words. A stalled request must stay steady until accepted. `done` must last a single cycle and must agree with `present`. The published size may change only on `done`, and no request may appear while idle. Only the bench's scenarios can show that the size is numerically correct: they cover a wrap below the bound, a memory as large as the bound or larger, a floating bus and two stuck data bits. The request counts tell which presence pass rejected a defective part, and reading the backing store after each run shows whether the saved words came back intact.

// File: rtl/probe_pkg.sv
package probe_pkg;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] PAT_LO_HI = 32'h5555_AAAA;
    localparam logic [WORD_W-1:0] PAT_HI_LO = 32'hAAAA_5555;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SAVE0, ST_SAVE1,
        ST_P1_W0, ST_P1_W4, ST_P1_R0,
        ST_P2_W0, ST_P2_W4, ST_P2_R0,
        ST_CHK, ST_LRD, ST_LWR, ST_LRB0, ST_LRBO,
        ST_RES0, ST_RES4
    } probe_st_e;
endpackage

// File: rtl/probe_bus_seq.sv
module probe_bus_seq #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [31:0]       go_wdata,
    output logic              ack,
    output logic [31:0]       rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_addr,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_rdata
);
    typedef enum logic [1:0] {B_IDLE, B_REQ, B_WAIT} bus_st_e;

    typedef struct packed {
        bus_st_e           st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
        logic              ack;
        logic [31:0]       rdata;
    } bus_t;

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d     = bus_q;
        bus_d.ack = 1'b0;
        case (bus_q.st)
            B_IDLE: if (go) begin
                bus_d.st    = B_REQ;
                bus_d.we    = go_we;
                bus_d.addr  = go_addr;
                bus_d.wdata = go_wdata;
            end
            B_REQ: if (req_ready) begin
                if (bus_q.we) begin
                    bus_d.ack = 1'b1;
                    bus_d.st  = B_IDLE;
                end else begin
                    bus_d.st  = B_WAIT;
                end
            end
            B_WAIT: if (rsp_valid) begin
                bus_d.rdata = rsp_rdata;
                bus_d.ack   = 1'b1;
                bus_d.st    = B_IDLE;
            end
            default: bus_d.st = B_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_q <= '0;
        else     bus_q <= bus_d;
    end

    assign req_valid = (bus_q.st == B_REQ);
    assign req_we    = bus_q.we;
    assign req_addr  = bus_q.addr;
    assign req_wdata = bus_q.wdata;
    assign ack       = bus_q.ack;
    assign rdata     = bus_q.rdata;
endmodule

// File: rtl/probe_offset_step.sv
module probe_offset_step #(
    parameter int unsigned SIZE_W = 33
) (
    input  logic [SIZE_W-1:0] ofs,
    input  logic [SIZE_W-1:0] limit,
    output logic [SIZE_W-1:0] ofs_next,
    output logic              at_limit
);
    assign ofs_next = {ofs[SIZE_W-2:0], 1'b0};
    assign at_limit = (ofs >= limit);
endmodule

// File: rtl/ram_size_probe.sv
module ram_size_probe #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] max_size,
    output logic              busy,
    output logic              done,
    output logic              present,
    output logic [ADDR_W-1:0] size_bytes,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_addr,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_rdata
);
    import probe_pkg::*;

    localparam int unsigned SIZE_W = ADDR_W + 1;

    typedef struct packed {
        probe_st_e         st;
        logic              pend;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] lim;
        logic [SIZE_W-1:0] ofs;
        logic [31:0]       save0;
        logic [31:0]       save1;
        logic [31:0]       probe_val;
        logic [31:0]       base_rd;
        logic [ADDR_W-1:0] found;
        logic [ADDR_W-1:0] size;
        logic              present;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              go, op_we, ack, at_limit;
    logic [ADDR_W-1:0] op_off;
    logic [31:0]       op_wdata, rdata;
    logic [SIZE_W-1:0] ofs_next;
    logic [ADDR_W-1:0] base_lat;

    probe_offset_step #(.SIZE_W(SIZE_W)) u_step (
        .ofs      (ctl_q.ofs),
        .limit    (ctl_q.lim),
        .ofs_next (ofs_next),
        .at_limit (at_limit)
    );

    probe_bus_seq #(.ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .go_we     (op_we),
        .go_addr   (ctl_q.base + op_off),
        .go_wdata  (op_wdata),
        .ack       (ack),
        .rdata     (rdata),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // operation selected by the current step
    always_comb begin
        op_we    = 1'b0;
        op_off   = '0;
        op_wdata = '0;
        case (ctl_q.st)
            ST_SAVE1: op_off = ADDR_W'(4);
            ST_P1_W0: begin op_we = 1'b1; op_wdata = PAT_LO_HI; end
            ST_P1_W4: begin op_we = 1'b1; op_wdata = PAT_HI_LO; op_off = ADDR_W'(4); end
            ST_P2_W0: begin op_we = 1'b1; op_wdata = PAT_HI_LO; end
            ST_P2_W4: begin op_we = 1'b1; op_wdata = PAT_LO_HI; op_off = ADDR_W'(4); end
            ST_LRD:   op_off = ctl_q.ofs[ADDR_W-1:0];
            ST_LWR:   begin op_we = 1'b1; op_wdata = ~ctl_q.probe_val; end
            ST_LRBO:  op_off = ctl_q.ofs[ADDR_W-1:0];
            ST_RES0:  begin op_we = 1'b1; op_wdata = ctl_q.save0; end
            ST_RES4:  begin op_we = 1'b1; op_wdata = ctl_q.save1; op_off = ADDR_W'(4); end
            default:  ;
        endcase
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        go         = 1'b0;

        if (ctl_q.st != ST_IDLE && ctl_q.st != ST_CHK && !ctl_q.pend) begin
            go         = 1'b1;
            ctl_d.pend = 1'b1;
        end

        case (ctl_q.st)
            ST_IDLE: if (start) begin
                ctl_d.base = base_addr;
                ctl_d.lim  = {1'b0, max_size};
                ctl_d.st   = ST_SAVE0;
            end
            ST_CHK: begin
                if (at_limit) begin
                    ctl_d.found = ctl_q.lim[ADDR_W-1:0];
                    ctl_d.st    = ST_RES0;
                end else begin
                    ctl_d.st    = ST_LRD;
                end
            end
            default: if (ack && ctl_q.pend) begin
                ctl_d.pend = 1'b0;
                case (ctl_q.st)
                    ST_SAVE0: begin ctl_d.save0 = rdata; ctl_d.st = ST_SAVE1; end
                    ST_SAVE1: begin ctl_d.save1 = rdata; ctl_d.st = ST_P1_W0; end
                    ST_P1_W0: ctl_d.st = ST_P1_W4;
                    ST_P1_W4: ctl_d.st = ST_P1_R0;
                    ST_P1_R0: begin
                        if (rdata != PAT_LO_HI) begin
                            ctl_d.found = '0;
                            ctl_d.st    = ST_RES0;
                        end else begin
                            ctl_d.st    = ST_P2_W0;
                        end
                    end
                    ST_P2_W0: ctl_d.st = ST_P2_W4;
                    ST_P2_W4: ctl_d.st = ST_P2_R0;
                    ST_P2_R0: begin
                        if (rdata != PAT_HI_LO) begin
                            ctl_d.found = '0;
                            ctl_d.st    = ST_RES0;
                        end else begin
                            ctl_d.ofs   = SIZE_W'(4);
                            ctl_d.st    = ST_CHK;
                        end
                    end
                    ST_LRD:  begin ctl_d.probe_val = rdata; ctl_d.st = ST_LWR; end
                    ST_LWR:  ctl_d.st = ST_LRB0;
                    ST_LRB0: begin ctl_d.base_rd = rdata; ctl_d.st = ST_LRBO; end
                    ST_LRBO: begin
                        if (rdata == ctl_q.base_rd) begin
                            ctl_d.found = ctl_q.ofs[ADDR_W-1:0];
                            ctl_d.st    = ST_RES0;
                        end else begin
                            ctl_d.ofs   = ofs_next;
                            ctl_d.st    = ST_CHK;
                        end
                    end
                    ST_RES0: ctl_d.st = ST_RES4;
                    ST_RES4: begin
                        ctl_d.size    = ctl_q.found;
                        ctl_d.present = (ctl_q.found != '0);
                        ctl_d.done    = 1'b1;
                        ctl_d.st      = ST_IDLE;
                    end
                    default: ctl_d.st = ST_IDLE;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign busy       = (ctl_q.st != ST_IDLE);
    assign done       = ctl_q.done;
    assign present    = ctl_q.present;
    assign size_bytes = ctl_q.size;
    assign base_lat   = ctl_q.base;
endmodule

// File: rtl/probe_checker.sv
module probe_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              present,
    input logic [ADDR_W-1:0] size_bytes,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic [ADDR_W-1:0] base_lat
);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    present_match_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (present == (size_bytes != '0)));

    // R7
    write_window_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_we) |-> (req_addr == base_lat || req_addr == base_lat + ADDR_W'(4)));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_we) && $stable(req_wdata)));

    // R9
    size_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(size_bytes) && $stable(present)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req_valid);
endmodule

bind ram_size_probe probe_checker #(.ADDR_W(ADDR_W)) chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .present    (present),
    .size_bytes (size_bytes),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .base_lat   (base_lat)
);

// File: tb/ram_size_probe_test.sv
module ram_size_probe_test;
    localparam logic [31:0] TB_BASE = 32'h2000_0000;
    localparam logic [31:0] KEEP0   = 32'h1234_5670;
    localparam logic [31:0] KEEP1   = 32'h0BAD_F004;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base_addr = TB_BASE;
    logic [31:0] max_size = 32'd4096;
    logic        busy, done, present;
    logic [31:0] size_bytes;
    logic        req_valid, req_we;
    logic        req_ready = 1'b1;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;

    // memory model: mode 0 good, 1 floating bus, 2 bit3 stuck low, 3 bit0 stuck low
    logic [31:0] mem [0:1023];
    int          real_bytes = 4096;
    int          mode = 0;
    bit          stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] bus_last = '0;
    bit          rd_pending = 1'b0;
    int          rd_wait = 0;
    logic [31:0] rd_data = '0;
    int          n_req = 0, n_bad = 0, n_done = 0;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    ram_size_probe #(.ADDR_W(32)) uut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .max_size(max_size), .busy(busy), .done(done), .present(present),
        .size_bytes(size_bytes), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    always #10 clk = ~clk;

    function automatic int word_idx(input logic [31:0] a);
        logic [31:0] off;
        off = (a - TB_BASE) & (real_bytes - 1);
        return int'(off >> 2);
    endfunction

    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        req_ready <= stall_en ? lfsr[3] : 1'b1;
        if (done) n_done <= n_done + 1;
        if (rd_pending) begin
            if (rd_wait == 0) begin
                rsp_valid  <= 1'b1;
                rsp_rdata  <= rd_data;
                rd_pending <= 1'b0;
            end else begin
                rd_wait <= rd_wait - 1;
            end
        end
        if (!rst && req_valid && req_ready) begin
            n_req <= n_req + 1;
            if (req_we) begin
                bus_last <= req_wdata;
                if (req_addr != TB_BASE && req_addr != TB_BASE + 4) n_bad <= n_bad + 1;
                case (mode)
                    0: mem[word_idx(req_addr)] <= req_wdata;
                    2: mem[word_idx(req_addr)] <= req_wdata & ~32'h8;
                    3: mem[word_idx(req_addr)] <= req_wdata & ~32'h1;
                    default: ;
                endcase
            end else begin
                rd_pending <= 1'b1;
                rd_wait    <= stall_en ? 2 : 0;
                rd_data    <= (mode == 1) ? bus_last : mem[word_idx(req_addr)];
            end
        end
    end

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic preload();
        for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 + i;
        mem[0] = KEEP0;
        mem[1] = KEEP1;
    endtask

    task automatic pulse_start(input logic [31:0] mx);
        @(negedge clk);
        max_size = mx;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_done();
        int d0;
        d0 = n_done;
        while (n_done == d0) @(negedge clk);
    endtask

    // one probe run against a configured memory, with all per-run checks
    task automatic run_case(input string req, input int rb, input int md,
                            input logic [31:0] mx, input bit stall,
                            input logic [31:0] exp_size, input int exp_reqs);
        int r0, b0, d0;
        logic [31:0] held;
        real_bytes = rb;
        mode       = md;
        stall_en   = stall;
        preload();
        r0 = n_req; b0 = n_bad; d0 = n_done;
        pulse_start(mx);
        wait_done();
        check_eq(req, "size", size_bytes, exp_size);
        check_eq("R8", "present", {31'b0, present}, {31'b0, exp_size != 0});
        if (exp_reqs >= 0) check_eq(req, "request count", n_req - r0, exp_reqs);
        check_eq("R7", "stray writes", n_bad - b0, 0);
        if (md != 1) begin
            check_eq("R1", "word0 restored", mem[0], KEEP0);
            check_eq("R1", "word1 restored", mem[1], KEEP1);
        end
        held = size_bytes;
        repeat (20) @(negedge clk);
        check_eq("R8", "done pulses", n_done - d0, 1);
        check_eq("R9", "size held", size_bytes, held);
        stall_en = 1'b0;
    endtask

    task automatic t_reset();
        check_eq("R8", "done at reset", {31'b0, done}, 0);
        check_eq("R9", "size at reset", size_bytes, 0);
        check_eq("R9", "busy at reset", {31'b0, busy}, 0);
        check_eq("R10", "req_valid at reset", {31'b0, req_valid}, 0);
    endtask

    task automatic t_start_while_busy();
        int d0;
        real_bytes = 256; mode = 0;
        preload();
        d0 = n_done;
        pulse_start(32'd4096);
        repeat (6) @(negedge clk);
        pulse_start(32'd8);
        wait_done();
        repeat (200) @(negedge clk);
        check_eq("R9", "size ignores busy start", size_bytes, 256);
        check_eq("R9", "one done for two starts", n_done - d0, 1);
        check_eq("R1", "word0 after busy start", mem[0], KEEP0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_case("R5", 256, 0, 32'd4096, 1'b0, 32'd256, -1);
        run_case("R10", 64, 0, 32'd4096, 1'b1, 32'd64, -1);
        run_case("R6", 4096, 0, 32'd4096, 1'b0, 32'd4096, -1);
        run_case("R6", 4096, 0, 32'd1024, 1'b1, 32'd1024, -1);
        run_case("R6", 4096, 0, 32'd4, 1'b0, 32'd4, 10);
        run_case("R4", 4096, 1, 32'd4096, 1'b0, 32'd0, 7);
        run_case("R2", 4096, 2, 32'd4096, 1'b0, 32'd0, 7);
        run_case("R3", 4096, 3, 32'd4096, 1'b1, 32'd0, 10);
        t_start_while_busy();
        run_case("R5", 8, 0, 32'd4096, 1'b1, 32'd8, -1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule